// File: doc/BRIEF.md
# Input Change and Interrupt Status Unit

This unit is the shared register group of a two-channel serial controller. It samples four asynchronous input pins and keeps a change register that records which pins toggled and whether the periodic frame tick fired. It also holds an interrupt status register built from the per-channel serial flags and its own input-change flag, an interrupt mask, and an eight-bit output port. The per-channel serial engines are outside the unit. Their transmit and receive flags arrive as levels on `chan_flags_i`.

A host reaches the unit through a single-cycle register interface (`rd_en_i`, `wr_en_i`, `addr_i`). Read data is combinational while `rd_en_i` is high. Side effects of a read happen at the clock edge that ends the read cycle. The output port has no plain write. Software sets bits through one address and clears bits through another, and the pins carry the inverse of the stored byte. The interrupt request is the OR of the status bits that the mask allows through.

Top module: `ics_unit`

## Requirements
- R1: After reset, the change register reads 0x40, the input port reads 0x0B, the status input-change bit (bit 7) is 0, the mask is 0x00 and `out_pins_o` is 0xFF.
- R2: A write to address 0x3B ORs `wdata_i` into the stored output byte.
- R3: A write to address 0x3F clears every stored output bit that is 1 in `wdata_i`.
- R4: `out_pins_o` always equals the bitwise complement of the stored output byte.
- R5: When synchronised pin k changes level, change bit k (low nibble) is set, and the upper nibble becomes exactly the set of pins that changed in that cycle (bit k+4). The status input-change bit 7 is also set.
- R6: A one-cycle `tick_i` pulse sets change bit 6 and status bit 7. Other upper-nibble bits are untouched unless a pin change occurs in the same cycle.
- R7: A read of address 0x13 returns the whole change register. At the end of that cycle it clears bits 3:0 and status bit 7, and keeps bits 7:4.
- R8: A pin change or tick in the same cycle as a change-register read wins over the clear: its bits and status bit 7 are set afterwards.
- R9: A read of address 0x17 returns the status byte: bit 0 channel A transmit, bit 1 channel A receive, bit 4 channel B transmit, bit 5 channel B receive (from `chan_flags_i` bits 0..3), bit 7 input change, all other bits 0. A write to 0x17 loads the mask.
- R10: `irq_o` is high exactly when the status byte ANDed with the mask is nonzero.
- R11: A read of address 0x37 returns {4'b0, pin levels}. A pin change applied before clock edge n appears there, and in the change register, after edge n+2.
- R12: A write to 0x13 changes nothing. A read of any other unlisted address, or any cycle with `rd_en_i` low, gives `rdata_o` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Periodic frame tick, one-cycle pulse |
| pins_i | input | 4 | Asynchronous input pins |
| chan_flags_i | input | 4 | {B rx, B tx, A rx, A tx} serial flags |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high |
| out_pins_o | output | 8 | Output port pins, inverted stored byte |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The case most likely to go wrong is a change-register read whose clearing edge is the same edge that registers a new pin change or a tick. The clear and the set then compete for the low nibble and for status bit 7. The bench lines this up in directed sequences: it toggles a pin two cycles ahead of the read, and in a separate sequence it pulses the tick during the read. Constrained random traffic also produces the overlap by chance. After each such edge the bench reads the register again and compares it with its own cycle model, in which the new event survives and the read-back value is the one held before the edge.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned N_PINS  = REG_W / 2;

  localparam logic [ADDR_W-1:0] A_CHANGE = 6'h13;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h17;
  localparam logic [ADDR_W-1:0] A_INPORT = 6'h37;
  localparam logic [ADDR_W-1:0] A_OUTSET = 6'h3B;
  localparam logic [ADDR_W-1:0] A_OUTCLR = 6'h3F;

  localparam int unsigned ST_A_TX = 0;
  localparam int unsigned ST_A_RX = 1;
  localparam int unsigned ST_B_TX = 4;
  localparam int unsigned ST_B_RX = 5;
  localparam int unsigned ST_PIN  = 7;
endpackage

// File: rtl/ics_pin_capture.sv
module ics_pin_capture #(
  parameter int unsigned N         = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic [N-1:0] RST_LEVEL = 4'b1011
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] evt_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][N-1:0] sync_q, sync_d;
  logic [N-1:0] lvl_q, lvl_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb sync_d[s] = pins_i;
    end else begin : g_rest
      always_comb sync_d[s] = sync_q[s-1];
    end
  end

  always_comb begin
    lvl_d = sync_q[LAST];
    evt_o = sync_q[LAST] ^ lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_LEVEL}};
      lvl_q  <= RST_LEVEL;
    end else begin
      sync_q <= sync_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  assert_level_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o == '0) |=> $stable(level_o));
endmodule

// File: rtl/ics_change_reg.sv
module ics_change_reg #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned TICK_SLOT = 2,
  parameter logic [REG_W-1:0] RST_VAL = 8'h40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_W/2-1:0]   evt_i,
  input  logic                 tick_i,
  input  logic                 rd_clr_i,
  output logic [REG_W-1:0]     chg_o,
  output logic                 ipc_o
);
  localparam int unsigned N = REG_W / 2;

  logic [REG_W-1:0] chg_q;
  logic [N-1:0]     low_d, up_d;
  logic             ipc_q, ipc_d, any_evt, upd_en;

  always_comb begin
    any_evt = |evt_i;
    low_d   = (rd_clr_i ? '0 : chg_q[N-1:0]) | evt_i;
    up_d    = any_evt ? evt_i : chg_q[REG_W-1:N];
    if (tick_i) up_d[TICK_SLOT] = 1'b1;
    ipc_d   = (ipc_q & ~rd_clr_i) | any_evt | tick_i;
    upd_en  = rd_clr_i | any_evt | tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= RST_VAL;
      ipc_q <= 1'b0;
    end else if (upd_en) begin
      chg_q <= {up_d, low_d};
      ipc_q <= ipc_d;
    end
  end

  assign chg_o = chg_q;
  assign ipc_o = ipc_q;

  assert_rd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0 && !tick_i) |=> (chg_q[N-1:0] == '0 && !ipc_q));
  assert_rd_keep_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0 && !tick_i) |=> $stable(chg_q[REG_W-1:N]));
  assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> (ipc_q && ((chg_q[N-1:0] & $past(evt_i)) == $past(evt_i))));
  assert_evt_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0 && !tick_i) |=> (chg_q[REG_W-1:N] == $past(evt_i)));
  assert_tick_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (chg_q[N+TICK_SLOT] && ipc_q));
endmodule

// File: rtl/ics_out_port.sv
module ics_out_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pins_o
);
  logic [W-1:0] q, d;
  logic         en;

  always_comb begin
    d  = q;
    if (set_we_i) d = d | wdata_i;
    if (clr_we_i) d = d & ~wdata_i;
    en = set_we_i | clr_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (en)  q <= d;
  end

  assign pins_o = ~q;

  assert_set_ors_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((~pins_o & $past(wdata_i)) == $past(wdata_i)));
  assert_clr_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((~pins_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/ics_unit.sv
module ics_unit
  import ics_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [N_PINS-1:0] PIN_RST = 4'b1011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_PINS-1:0] pins_i,
  input  logic [3:0]        chan_flags_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  out_pins_o,
  output logic              irq_o
);
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [N_PINS-1:0] level, evt;
  logic [REG_W-1:0]  chg, status, mask_q, mask_d;
  logic              ipc, rd_chg, set_we, clr_we, mask_we;

  always_comb begin
    rd_chg  = rd_en_i && (addr_i == A_CHANGE);
    set_we  = wr_en_i && (addr_i == A_OUTSET);
    clr_we  = wr_en_i && (addr_i == A_OUTCLR);
    mask_we = wr_en_i && (addr_i == A_STATUS);
    mask_d  = wdata_i;
  end

  ics_pin_capture #(.N(N_PINS), .STAGES(SYNC_STAGES), .RST_LEVEL(PIN_RST)) u_pins (
    .clk_i(clk_i), .rst_ni(rst_n), .pins_i(pins_i), .level_o(level), .evt_o(evt));

  ics_change_reg #(.REG_W(REG_W), .TICK_SLOT(2), .RST_VAL(8'h40)) u_chg (
    .clk_i(clk_i), .rst_ni(rst_n), .evt_i(evt), .tick_i(tick_i),
    .rd_clr_i(rd_chg), .chg_o(chg), .ipc_o(ipc));

  ics_out_port #(.W(REG_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_n), .set_we_i(set_we), .clr_we_i(clr_we),
    .wdata_i(wdata_i), .pins_o(out_pins_o));

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (mask_we)  mask_q <= mask_d;
  end

  always_comb begin
    status          = '0;
    status[ST_A_TX] = chan_flags_i[0];
    status[ST_A_RX] = chan_flags_i[1];
    status[ST_B_TX] = chan_flags_i[2];
    status[ST_B_RX] = chan_flags_i[3];
    status[ST_PIN]  = ipc;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_CHANGE: rdata_o = chg;
        A_STATUS: rdata_o = status;
        A_INPORT: rdata_o = {{(REG_W-N_PINS){1'b0}}, level};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status & mask_q);

  assert_mask_load_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask_we && wdata_i == '0) |=> !irq_o);
endmodule

// File: tb/tb_ics_unit.sv
module tb_ics_unit;
  import ics_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, tick, rd, wr;
  logic [3:0] pins, ch;
  logic [5:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata, outp;
  logic       irq;

  ics_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pins_i(pins), .chan_flags_i(ch),
    .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .out_pins_o(outp), .irq_o(irq));

  int checks = 0;
  int errors = 0;

  logic [3:0] m_s1, m_s2, m_lvl;
  logic [7:0] m_chg, m_mask, m_out;
  logic       m_ipc;

  function automatic logic [7:0] m_status();
    return {m_ipc, 1'b0, ch[3], ch[2], 2'b00, ch[1], ch[0]};
  endfunction

  function automatic logic [7:0] exp_rdata();
    if (!rd) return 8'h00;
    case (addr)
      A_CHANGE: return m_chg;
      A_STATUS: return m_status();
      A_INPORT: return {4'h0, m_lvl};
      default:  return 8'h00;
    endcase
  endfunction

  function automatic string auto_tag();
    if (!rd) return "R12";
    case (addr)
      A_CHANGE: return "R7";
      A_STATUS: return "R9";
      A_INPORT: return "R11";
      default:  return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [3:0] ev, low, up;
    logic rdc;
    ev  = m_s2 ^ m_lvl;
    rdc = rd && (addr == A_CHANGE);
    low = (rdc ? 4'h0 : m_chg[3:0]) | ev;
    up  = (ev != 0) ? ev : m_chg[7:4];
    if (tick) up[2] = 1'b1;
    m_ipc = (m_ipc & ~rdc) | (|ev) | tick;
    m_chg = {up, low};
    m_lvl = m_s2; m_s2 = m_s1; m_s1 = pins;
    if (wr) begin
      case (addr)
        A_STATUS: m_mask = wdata;
        A_OUTSET: m_out  = m_out | wdata;
        A_OUTCLR: m_out  = m_out & ~wdata;
        default: ;
      endcase
    end
  endtask

  task automatic step(input string tag);
    #1;
    check((tag == "") ? auto_tag() : tag, rdata, exp_rdata());
    check("R10", {7'b0, irq}, {7'b0, |(m_status() & m_mask)});
    check("R4", outp, ~m_out);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    rd = 0; wr = 0; tick = 0;
  endtask

  task automatic do_rd(input logic [5:0] a, input string tag);
    rd = 1; addr = a; step(tag);
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [7:0] d, input string tag);
    wr = 1; addr = a; wdata = d; step(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; tick = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    pins = 4'b1011; ch = 0;
    m_s1 = 4'b1011; m_s2 = 4'b1011; m_lvl = 4'b1011;
    m_chg = 8'h40; m_mask = 0; m_out = 0; m_ipc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    do_rd(A_CHANGE, "R1");
    do_rd(A_INPORT, "R1");
    do_rd(A_STATUS, "R1");
    // R2 / R3 output set and clear
    do_wr(A_OUTSET, 8'hA5, "R2");
    do_wr(A_OUTSET, 8'h0F, "R2");
    do_wr(A_OUTCLR, 8'h81, "R3");
    idle(1);
    // R12 write to change address ignored, unmapped read zero
    do_wr(A_CHANGE, 8'hFF, "R12");
    do_rd(A_CHANGE, "R12");
    do_rd(6'h00, "R12");
    // R5 / R11 pin change and latency
    pins = 4'b1001; idle(1);
    do_rd(A_INPORT, "R11");
    do_rd(A_INPORT, "R11");
    do_rd(A_CHANGE, "R5");
    do_rd(A_CHANGE, "R7");
    // R6 tick alone
    tick = 1; idle(1);
    do_rd(A_CHANGE, "R6");
    // R8 tick during read, then pin change landing on read edge
    tick = 1; do_rd(A_CHANGE, "R8");
    do_rd(A_CHANGE, "R8");
    pins = 4'b0001; idle(1); idle(1);
    do_rd(A_CHANGE, "R8");
    do_rd(A_CHANGE, "R8");
    // R9 / R10 status layout and mask
    ch = 4'b1111; do_rd(A_STATUS, "R9");
    do_wr(A_STATUS, 8'h10, "R10");
    ch = 4'b0100; idle(1);
    ch = 4'b1011; idle(1);
    do_wr(A_STATUS, 8'h80, "R10");
    pins = 4'b0011; idle(4);
    do_rd(A_CHANGE, "R7");
    idle(1);

    void'($urandom(32'h1C5));
    for (int i = 0; i < 4000; i++) begin
      int op;
      ch = 4'($urandom);
      if (($urandom % 8) == 0) pins = 4'($urandom);
      tick = (($urandom % 16) == 0);
      op = $urandom % 9;
      case (op)
        0: do_rd(A_CHANGE, "");
        1: do_rd(A_STATUS, "");
        2: do_rd(A_INPORT, "");
        3: do_rd(6'($urandom), "");
        4: do_wr(A_STATUS, 8'($urandom), "R9");
        5: do_wr(A_OUTSET, 8'($urandom), "R2");
        6: do_wr(A_OUTCLR, 8'($urandom), "R3");
        7: do_wr(A_CHANGE, 8'($urandom), "R12");
        default: idle(1);
      endcase
    end
    finish_run();
  end
endmodule